// File: doc/BRIEF.md
# Cascadable 8B/10B Line Encoder

This block turns bytes into 10-bit transmission code groups following the standard Ethernet 8B/10B code tables, and keeps track of running disparity from one word to the next. In single-width mode one byte and its control flag produce one code group. In double-width mode two encoder slices are chained within the same cycle. The lower slice encodes first. Its ending disparity drives the upper slice, and the disparity at the end of the upper slice is stored for the next word.

Every output is registered, so a word appears on the outputs one clock after it is presented. The stored disparity can be overridden for a single word. A control byte that is not one of the twelve legal special characters raises a per-lane error flag. A raw pass-through path lets pre-encoded groups reach the output with the same one-cycle latency.

Top module: `enc8b10b_cascade`

## Requirements
- R1: With `wide_mode`=0, `data_in[7:0]` and `ctl_in[0]` give one code group on `code_out[9:0]` one clock later. `code_out[19:10]` and `kerr_out[1]` are then 0, and `data_in[15:8]` and `ctl_in[1]` have no effect.
- R2: With `wide_mode`=1, byte `data_in[7:0]` is encoded to `code_out[9:0]` and byte `data_in[15:8]` to `code_out[19:10]`. The upper byte is encoded with the ending disparity of the lower byte from the same word.
- R3: A synchronous reset (`rst`=1) clears `code_out`, `kerr_out` and the running disparity. Disparity is negative after reset (`rd_out`=0), so a K28.5 sent first comes out as 0x17C.
- R4: Each word is encoded with the stored disparity. A group containing five ones leaves the disparity unchanged, and any other group flips it. The disparity at the end of the word appears on `rd_out` one clock later.
- R5: When `rd_force`=1, `rd_force_val` (1 = positive) replaces the stored disparity as the starting disparity of that word only.
- R6: Code bit a is `code_out` bit 0 and j is bit 9, in the order abcdeifghj. Bit 0 is sent first, and the lower group is sent before the upper group. Data codes follow the standard 5b/6b and 3b/4b tables.
- R7: Every group holds four, five or six ones. An unforced stream of encoded words never has more than five equal bits in a row.
- R8: D.x.7 uses the alternate form (0111 under negative disparity, 1000 under positive) for x = 17, 18 or 20 when disparity is negative after the 6-bit sub-block, and for x = 11, 13 or 14 when it is positive.
- R9: With the control flag set, the twelve legal special characters are encoded in both disparities. These are K28.0 to K28.7 (bytes 0x1C, 0x3C, ..., 0xFC) and K23.7, K27.7, K29.7 and K30.7 (bytes 0xF7, 0xFB, 0xFD, 0xFE).
- R10: A control byte outside that set sets the lane's `kerr_out` bit one clock later. The lane then outputs K28.5 in its current disparity (0x17C if negative, 0x283 if positive), and the disparity advances as it would for K28.5.
- R11: With `bypass`=1, `raw_in` appears on `code_out` one clock later, `kerr_out` is 0, and the stored disparity is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = both slices chained, 0 = lower slice only |
| bypass | input | 1 | Pass `raw_in` through instead of encoding |
| rd_force | input | 1 | Override the starting disparity for this word |
| rd_force_val | input | 1 | Disparity used when forced (1 = positive) |
| data_in | input | 16 | Bytes, lower lane in bits 7:0 |
| ctl_in | input | 2 | Control flag per lane |
| raw_in | input | 20 | Pre-encoded groups for pass-through |
| code_out | output | 20 | Registered code groups, lower lane in bits 9:0 |
| kerr_out | output | 2 | Illegal control character flag per lane |
| rd_out | output | 1 | Running disparity after the last encoded word (1 = positive) |

## Verification
The assertions check on every cycle that each group has four to six ones. They also check that the ones count of the lower group matches the disparity it started from, forced or stored, and that the upper group matches the ending disparity of the lower group. Further assertions cover the zeroed upper lane in single-width mode, that an error flag only ever comes with a K28.5 output, and that the pass-through path is exact and leaves disparity unchanged. Only the bench's scenarios can show that each code equals the table entry: it sweeps every byte in both disparities and every legal and illegal special character. The bench scenarios also cover the alternate D.x.7 choice and the bound on run length across long unforced streams.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

    localparam int SYM_W = 8;
    localparam int GRP_W = 10;

    typedef struct packed {
        logic [GRP_W-1:0] grp;     // bit 0 = a (sent first)
        logic             rd_end;  // 1 = positive
        logic             kbad;
    } sym_res_t;

    // 5b/6b sub-table, negative-disparity form, literal written abcdei
    function automatic logic [5:0] six_neg(input logic [4:0] x);
        logic [5:0] s;
        case (x)
            5'd0:  s = 6'b100111;  5'd1:  s = 6'b011101;
            5'd2:  s = 6'b101101;  5'd3:  s = 6'b110001;
            5'd4:  s = 6'b110101;  5'd5:  s = 6'b101001;
            5'd6:  s = 6'b011001;  5'd7:  s = 6'b111000;
            5'd8:  s = 6'b111001;  5'd9:  s = 6'b100101;
            5'd10: s = 6'b010101;  5'd11: s = 6'b110100;
            5'd12: s = 6'b001101;  5'd13: s = 6'b101100;
            5'd14: s = 6'b011100;  5'd15: s = 6'b010111;
            5'd16: s = 6'b011011;  5'd17: s = 6'b100011;
            5'd18: s = 6'b010011;  5'd19: s = 6'b110010;
            5'd20: s = 6'b001011;  5'd21: s = 6'b101010;
            5'd22: s = 6'b011010;  5'd23: s = 6'b111010;
            5'd24: s = 6'b110011;  5'd25: s = 6'b100110;
            5'd26: s = 6'b010110;  5'd27: s = 6'b110110;
            5'd28: s = 6'b001110;  5'd29: s = 6'b101110;
            5'd30: s = 6'b011110;  default: s = 6'b101011;
        endcase
        return s;
    endfunction

    // 3b/4b sub-table, negative-disparity form, literal written fghj
    function automatic logic [3:0] four_neg(input logic [2:0] y);
        logic [3:0] s;
        case (y)
            3'd0: s = 4'b1011;  3'd1: s = 4'b1001;
            3'd2: s = 4'b0101;  3'd3: s = 4'b1100;
            3'd4: s = 4'b1101;  3'd5: s = 4'b1010;
            3'd6: s = 4'b0110;  default: s = 4'b1110;
        endcase
        return s;
    endfunction

    function automatic logic legal_k(input logic [7:0] b);
        return (b[4:0] == 5'd28) || (b == 8'hF7) || (b == 8'hFB) ||
               (b == 8'hFD) || (b == 8'hFE);
    endfunction

    function automatic sym_res_t encode_sym(input logic [7:0] b,
                                            input logic       is_k,
                                            input logic       rd_in);
        sym_res_t   r;
        logic [7:0] v;
        logic [5:0] s6;
        logic [3:0] s4;
        logic       k28, rd6, alt, pol4;
        r.kbad = is_k && !legal_k(b);
        v      = r.kbad ? 8'hBC : b;
        k28    = is_k && (v[4:0] == 5'd28);
        s6     = k28 ? 6'b001111 : six_neg(v[4:0]);
        if (rd_in && (k28 || ($countones(s6) != 3) || (v[4:0] == 5'd7)))
            s6 = ~s6;
        rd6 = ($countones(s6) == 3) ? rd_in : ~rd_in;
        alt = (v[7:5] == 3'd7) &&
              (is_k || (rd6  && (v[4:0] == 5'd11 || v[4:0] == 5'd13 || v[4:0] == 5'd14))
                    || (!rd6 && (v[4:0] == 5'd17 || v[4:0] == 5'd18 || v[4:0] == 5'd20)));
        s4   = alt ? 4'b0111 : four_neg(v[7:5]);
        pol4 = k28 ? 1'b1 : rd6;
        if (pol4 && (($countones(s4) != 2) || (v[7:5] == 3'd3)))
            s4 = ~s4;
        if (k28 && rd_in)
            s4 = ~s4;
        r.grp    = {s4[0], s4[1], s4[2], s4[3],
                    s6[0], s6[1], s6[2], s6[3], s6[4], s6[5]};
        r.rd_end = ($countones(r.grp) == 5) ? rd_in : ~rd_in;
        return r;
    endfunction

endpackage

// File: rtl/enc_slice.sv
module enc_slice
    import enc8b10b_pkg::*;
(
    input  logic             active,
    input  logic [SYM_W-1:0] byte_in,
    input  logic             is_k,
    input  logic             rd_in,
    output logic [GRP_W-1:0] grp,
    output logic             kbad,
    output logic             rd_out
);

    sym_res_t res;

    always_comb begin
        res = encode_sym(byte_in, is_k, rd_in);
        if (active) begin
            grp    = res.grp;
            kbad   = res.kbad;
            rd_out = res.rd_end;
        end else begin
            grp    = '0;
            kbad   = 1'b0;
            rd_out = rd_in;
        end
    end

    // R7: every produced group carries a legal weight
    always_comb begin
        assert_group_weight_R7: assert (!active ||
            (($countones(res.grp) >= 4) && ($countones(res.grp) <= 6)));
    end

endmodule

// File: rtl/enc_out_stage.sv
module enc_out_stage #(
    parameter int CODE_W = 20,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic [CODE_W-1:0] raw_in,
    input  logic [CODE_W-1:0] enc_word,
    input  logic [LANES-1:0]  enc_bad,
    input  logic              rd_next,
    output logic [CODE_W-1:0] code_q,
    output logic [LANES-1:0]  kerr_q,
    output logic              rd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            kerr_q <= '0;
            rd_q   <= 1'b0;
        end else if (bypass) begin
            code_q <= raw_in;
            kerr_q <= '0;
        end else begin
            code_q <= enc_word;
            kerr_q <= enc_bad;
            rd_q   <= rd_next;
        end
    end

    // R11: pass-through is exact and leaves disparity alone
    assert_bypass_exact_R11: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (code_q == $past(raw_in)) && (kerr_q == '0) && (rd_q == $past(rd_q)));

endmodule

// File: rtl/enc8b10b_cascade.sv
module enc8b10b_cascade
    import enc8b10b_pkg::*;
#(
    parameter int NUM_SLICES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wide_mode,
    input  logic                        bypass,
    input  logic                        rd_force,
    input  logic                        rd_force_val,
    input  logic [NUM_SLICES*SYM_W-1:0] data_in,
    input  logic [NUM_SLICES-1:0]       ctl_in,
    input  logic [NUM_SLICES*GRP_W-1:0] raw_in,
    output logic [NUM_SLICES*GRP_W-1:0] code_out,
    output logic [NUM_SLICES-1:0]       kerr_out,
    output logic                        rd_out
);

    localparam int CODE_W = NUM_SLICES * GRP_W;

    logic                  rd_q;
    logic [NUM_SLICES:0]   rd_chain;
    logic [CODE_W-1:0]     enc_word;
    logic [NUM_SLICES-1:0] enc_bad;

    assign rd_chain[0] = rd_force ? rd_force_val : rd_q;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_lane
        localparam bit FIRST = (i == 0);
        logic lane_on;
        assign lane_on = FIRST | wide_mode;

        enc_slice u_slice (
            .active  (lane_on),
            .byte_in (data_in[i*SYM_W +: SYM_W]),
            .is_k    (ctl_in[i]),
            .rd_in   (rd_chain[i]),
            .grp     (enc_word[i*GRP_W +: GRP_W]),
            .kbad    (enc_bad[i]),
            .rd_out  (rd_chain[i+1])
        );
    end

    enc_out_stage #(.CODE_W(CODE_W), .LANES(NUM_SLICES)) u_out (
        .clk      (clk),
        .rst      (rst),
        .bypass   (bypass),
        .raw_in   (raw_in),
        .enc_word (enc_word),
        .enc_bad  (enc_bad),
        .rd_next  (rd_chain[NUM_SLICES]),
        .code_q   (code_out),
        .kerr_q   (kerr_out),
        .rd_q     (rd_q)
    );

    assign rd_out = rd_q;

    // R4 / R5: lower group weight agrees with its starting disparity
    assert_start_column_R4: assert property (@(posedge clk) disable iff (rst)
        !bypass |=> (($past(rd_force) ? $past(rd_force_val) : $past(rd_q))
                     ? ($countones(code_out[GRP_W-1:0]) <= 5)
                     : ($countones(code_out[GRP_W-1:0]) >= 5)));

    // R10: an error flag always comes with K28.5 in either disparity
    assert_bad_k_sub_R10: assert property (@(posedge clk) disable iff (rst)
        kerr_out[0] |-> (code_out[GRP_W-1:0] == 10'h17C) || (code_out[GRP_W-1:0] == 10'h283));

    if (NUM_SLICES > 1) begin : g_chain_chk
        // R1: upper lane silent in single-width mode
        assert_upper_idle_R1: assert property (@(posedge clk) disable iff (rst)
            (!wide_mode && !bypass) |=>
                (code_out[CODE_W-1:GRP_W] == '0) && (kerr_out[NUM_SLICES-1:1] == '0));

        // R2: upper group starts from the lower group's ending disparity
        assert_chain_link_R2: assert property (@(posedge clk) disable iff (rst)
            (wide_mode && !bypass) |=>
                ((($past(rd_force) ? $past(rd_force_val) : $past(rd_q))
                  ^ ($countones(code_out[GRP_W-1:0]) != 5))
                 ? ($countones(code_out[2*GRP_W-1:GRP_W]) <= 5)
                 : ($countones(code_out[2*GRP_W-1:GRP_W]) >= 5)));
    end

endmodule

// File: tb/tb_enc8b10b_cascade.sv
module tb_enc8b10b_cascade;

    logic        clk = 1'b0;
    logic        rst;
    logic        wide_mode, bypass, rd_force, rd_force_val;
    logic [15:0] data_in;
    logic [1:0]  ctl_in;
    logic [19:0] raw_in;
    logic [19:0] code_out;
    logic [1:0]  kerr_out;
    logic        rd_out;

    always #2.5 clk = ~clk;  // 200 MHz

    enc8b10b_cascade dut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .bypass(bypass),
        .rd_force(rd_force), .rd_force_val(rd_force_val), .data_in(data_in),
        .ctl_in(ctl_in), .raw_in(raw_in), .code_out(code_out),
        .kerr_out(kerr_out), .rd_out(rd_out)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic        mrd;       // model running disparity
    int          run_len;
    logic        run_bit;
    logic [15:0] lf = 16'hACE1;

    localparam logic [5:0] T6 [32] = '{
        6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
        6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
        6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
        6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
        6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
        6'b011110, 6'b101011};
    localparam logic [3:0] T4 [8] = '{
        4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    localparam logic [7:0] KLIST [12] = '{
        8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
        8'hF7, 8'hFB, 8'hFD, 8'hFE};

    function automatic logic [9:0] ref_enc(input logic [7:0] b, input logic k,
                                           input logic rd, output logic rd_o,
                                           output logic bad);
        logic [7:0] v;
        logic [5:0] c6;
        logic [3:0] c4;
        logic [4:0] x;
        logic [2:0] y;
        logic       r6, a7;
        logic [9:0] g;
        bad = k && !(b[4:0] == 5'd28 || b == 8'hF7 || b == 8'hFB ||
                     b == 8'hFD || b == 8'hFE);
        v = bad ? 8'hBC : b;
        x = v[4:0];
        y = v[7:5];
        if (k && x == 5'd28) begin
            c6 = 6'b001111;
            c4 = (y == 3'd7) ? 4'b0111 : T4[y];
            if (c4 == 4'b1100 || $countones(c4) != 2) c4 = ~c4;
            if (rd) begin c6 = ~c6; c4 = ~c4; end
        end else begin
            c6 = T6[x];
            if (rd && ($countones(c6) != 3 || x == 5'd7)) c6 = ~c6;
            r6 = ($countones(c6) == 3) ? rd : !rd;
            a7 = (y == 3'd7) && (k || (r6 ? (x == 11 || x == 13 || x == 14)
                                          : (x == 17 || x == 18 || x == 20)));
            c4 = a7 ? 4'b0111 : T4[y];
            if (r6 && ($countones(c4) != 2 || c4 == 4'b1100)) c4 = ~c4;
        end
        g = {c4[0], c4[1], c4[2], c4[3], c6[0], c6[1], c6[2], c6[3], c6[4], c6[5]};
        rd_o = ($countones(g) == 5) ? rd : !rd;
        return g;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_lf();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic feed_run(input logic [9:0] g, input string req);
        bit ok = 1;
        for (int i = 0; i < 10; i++) begin
            if (run_len != 0 && g[i] == run_bit) run_len++;
            else begin run_len = 1; run_bit = g[i]; end
            if (run_len > 5) ok = 0;
        end
        chk(ok, req, run_len, 5);
    endtask

    task automatic word(input logic wide, input logic [15:0] d, input logic [1:0] c,
                        input logic frc, input logic fv, input string req,
                        input bit runchk);
        logic [9:0]  lo, hi;
        logic        rm, re, blo, bhi, eff;
        logic [19:0] ec;
        logic [1:0]  ek;
        wide_mode = wide; bypass = 0; data_in = d; ctl_in = c;
        rd_force = frc; rd_force_val = fv;
        eff = frc ? fv : mrd;
        lo  = ref_enc(d[7:0], c[0], eff, rm, blo);
        if (wide) begin
            hi = ref_enc(d[15:8], c[1], rm, re, bhi);
        end else begin
            hi = '0; re = rm; bhi = 0;
        end
        ec = {hi, lo};
        ek = {bhi, blo};
        mrd = re;
        tick();
        chk(code_out == ec, req, code_out, ec);
        chk(kerr_out == ek, req, kerr_out, ek);
        chk(rd_out == mrd, req, rd_out, mrd);
        if (runchk) begin
            feed_run(code_out[9:0], "R7");
            if (wide) feed_run(code_out[19:10], "R7");
        end
        rd_force = 0;
    endtask

    function automatic logic [7:0] pick_k();
        return KLIST[lf[3:0] % 12];
    endfunction

    initial begin
        rst = 1; wide_mode = 0; bypass = 0; rd_force = 0; rd_force_val = 0;
        data_in = '0; ctl_in = '0; raw_in = '0;
        mrd = 0; run_len = 0; run_bit = 0;
        repeat (3) tick();
        // R3: reset state
        chk(code_out == '0, "R3", code_out, 0);
        chk(kerr_out == '0, "R3", kerr_out, 0);
        chk(rd_out == 1'b0, "R3", rd_out, 0);
        rst = 0;

        // R3: first K28.5 after reset uses the negative column
        word(0, 16'h00BC, 2'b01, 0, 0, "R3", 0);
        chk(code_out[9:0] == 10'h17C, "R3", code_out[9:0], 10'h17C);

        // R6 / R8 / R1 / R5: every data byte under both forced disparities,
        // upper lane inputs randomized and expected to be ignored
        for (int r = 0; r < 2; r++) begin
            for (int d = 0; d < 256; d++) begin
                step_lf();
                word(0, {lf[7:0], d[7:0]}, {lf[8], 1'b0}, 1, r[0], "R6", 0);
            end
        end

        // R9: legal special characters in both disparities
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 12; i++)
                word(0, {8'h00, KLIST[i]}, 2'b01, 1, r[0], "R9", 0);

        // R10: illegal control bytes become K28.5 and flag the lane
        for (int r = 0; r < 2; r++) begin
            word(0, 16'h0000, 2'b01, 1, r[0], "R10", 0);
            word(0, 16'h00FF, 2'b01, 1, r[0], "R10", 0);
            word(0, 16'h001D, 2'b01, 1, r[0], "R10", 0);
            word(0, 16'h00F6, 2'b01, 1, r[0], "R10", 0);
            chk(code_out[9:0] == (r ? 10'h283 : 10'h17C), "R10", code_out[9:0],
                r ? 10'h283 : 10'h17C);
        end

        // R4 / R7: unforced single-width stream with occasional specials
        run_len = 0;
        for (int n = 0; n < 400; n++) begin
            step_lf();
            if (lf[15:13] == 3'b000) word(0, {8'h00, pick_k()}, 2'b01, 0, 0, "R4", 1);
            else                     word(0, {8'h00, lf[7:0]}, 2'b00, 0, 0, "R4", 1);
        end

        // R2 / R5: wide mode, every lower byte under both forced disparities
        for (int r = 0; r < 2; r++) begin
            for (int d = 0; d < 256; d++) begin
                step_lf();
                word(1, {lf[11:4], d[7:0]}, 2'b00, 1, r[0], "R2", 0);
            end
        end

        // R2 / R7 / R10: unforced wide stream, specials and bad controls in either lane
        run_len = 0;
        for (int n = 0; n < 400; n++) begin
            logic [7:0] b0, b1;
            logic [1:0] c;
            step_lf();
            b0 = lf[7:0];
            b1 = lf[15:8];
            c  = 2'b00;
            if (lf[2:0] == 3'd1) begin b0 = pick_k(); c[0] = 1; end
            step_lf();
            if (lf[2:0] == 3'd2) begin b1 = pick_k(); c[1] = 1; end
            if (lf[5:0] == 6'd9) c[1] = 1;  // may be an illegal control byte
            word(1, {b1, b0}, c, 0, 0, "R2", 1);
        end

        // R11: pass-through, disparity must survive it
        for (int n = 0; n < 6; n++) begin
            logic [19:0] rv;
            step_lf();
            rv = {lf[3:0], lf};
            bypass = 1; raw_in = rv; data_in = ~lf; ctl_in = 2'b11;
            rd_force = 1; rd_force_val = ~mrd;
            tick();
            chk(code_out == rv, "R11", code_out, rv);
            chk(kerr_out == 2'b00, "R11", kerr_out, 0);
            chk(rd_out == mrd, "R11", rd_out, mrd);
            rd_force = 0;
        end
        word(1, 16'h1234, 2'b00, 0, 0, "R11", 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule